// File: doc/BRIEF.md
# Neighbour-Count Threshold Bit Processor

A one-bit processing element for a mesh-connected image array. Each clock it takes the eight bits arriving from its neighbours and masks each with its own enable. It counts how many of the enabled neighbours are high and asserts a threshold hit when that count is strictly greater than a 3-bit threshold code. The hit is OR-ed with operand register B. Operand register A and this combined bit then feed two independent two-input Boolean functions. One function drives all eight neighbour output bits. The other supplies the bit that can be written back to local memory.

The element holds the two one-bit operand registers and a 16-bit local memory. One control word is applied per clock. It carries load enables for A and B, a clear for B, a write enable for memory, a 4-bit memory address, both 4-bit function codes and the threshold. Clearing B turns the second operand into the bare threshold hit, so a pure neighbourhood operation can run. The addressed memory bit is visible at all times on a read port.

Top module: `nbr_thresh_pe`

## Requirements
- R1: While rst_ni is low, A, B and every memory bit are cleared. After reset, A, B and the read port at every address all show 0.
- R2: A neighbour input whose enable bit is 0 does not add to the count. With all enables at 0 the threshold hit is never asserted.
- R3: The threshold hit is 1 only when the count of enabled high neighbours is strictly greater than thresh_i. A count equal to thresh_i gives 0.
- R4: The Boolean unit's first input is A. Its second input is B OR the threshold hit.
- R5: Every bit of nbr_o equals fn_nbr_i[{A, B|hit}], combinationally in the same cycle. Bit index 0 of the code corresponds to both inputs being 0.
- R6: When write_d_i is 1, the memory bit at addr_i takes fn_mem_i[{A, B|hit}] at the clock edge. rd_bit_o always shows the memory bit at addr_i.
- R7: load_a_i (or load_b_i) loads the register from the memory bit at addr_i at the clock edge. When this happens in the same cycle as a write to that address, the register receives the value held before the write.
- R8: clr_b_i sets B to 0 at the clock edge and takes priority over load_b_i.
- R9: With write_d_i at 0, no memory bit changes. With no load or clear enable, A and B keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nbr_i | input | 8 | Bits from the eight neighbours |
| nbr_en_i | input | 8 | Per-neighbour gate enables |
| thresh_i | input | 3 | Threshold code; hit when count > code |
| load_a_i | input | 1 | Load A from addressed memory bit |
| load_b_i | input | 1 | Load B from addressed memory bit |
| clr_b_i | input | 1 | Clear B (wins over load_b_i) |
| write_d_i | input | 1 | Write memory-side function result |
| addr_i | input | 4 | Local memory bit address |
| fn_nbr_i | input | 4 | Truth table for the neighbour output |
| fn_mem_i | input | 4 | Truth table for the memory write bit |
| nbr_o | output | 8 | Neighbour output, all bits equal |
| rd_bit_o | output | 1 | Memory bit at addr_i |
| a_o | output | 1 | Operand register A |
| b_o | output | 1 | Operand register B |

## Verification
The hazard to cover is a load of A or B and a memory write to the same address in one cycle. Both take effect at the same edge, so the register must capture the bit as it stood before the write. The bench provokes this with directed cycles that set load_a_i, load_b_i and write_d_i together, with a function code that changes the stored bit. It judges the result through a_o, b_o and rd_bit_o in the following cycle against its behavioural model. Randomised control words then mix loads, clears, writes and threshold hits freely, and every output is compared with the model on every clock.

// File: rtl/nbr_pe_pkg.sv
package nbr_pe_pkg;
  localparam int unsigned NBR_N    = 8;
  localparam int unsigned THR_W    = 3;
  localparam int unsigned MEM_D    = 16;
  localparam int unsigned ADDR_W   = $clog2(MEM_D);
  localparam int unsigned FN_W     = 4;
  localparam int unsigned CNT_W    = $clog2(NBR_N + 1);
endpackage

// File: rtl/nbr_count.sv
module nbr_count #(
  parameter int unsigned N     = 8,
  parameter int unsigned THR_W = 3
) (
  input  logic             rst_ni,
  input  logic [N-1:0]     nbr_i,
  input  logic [N-1:0]     en_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic [N-1:0]     gated;
  logic [CNT_W-1:0] cnt;

  assign gated = nbr_i & en_i;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(N); i++) cnt = cnt + CNT_W'(gated[i]);
  end

  assign hit_o = (cnt > CNT_W'(thr_i));

  // R2
  always_comb begin
    if (rst_ni && en_i == '0) no_en_no_hit_chk: assert (!hit_o);
  end
endmodule

// File: rtl/bit_mem.sv
module bit_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              rd_o
);
  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rd_o = mem_q[addr_i];

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
  // R6
  mem_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/bool_unit.sv
module bool_unit #(
  parameter int unsigned OUTS = 2
) (
  input  logic            a_i,
  input  logic            b_i,
  input  logic [4*OUTS-1:0] fn_i,
  output logic [OUTS-1:0] y_o
);
  logic [1:0] idx;
  assign idx = {a_i, b_i};

  for (genvar g = 0; g < int'(OUTS); g++) begin : g_fn
    logic [3:0] tt;
    assign tt     = fn_i[4*g +: 4];
    assign y_o[g] = tt[idx];
  end
endmodule

// File: rtl/nbr_thresh_pe.sv
module nbr_thresh_pe
  import nbr_pe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBR_N-1:0]  nbr_i,
  input  logic [NBR_N-1:0]  nbr_en_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              load_a_i,
  input  logic              load_b_i,
  input  logic              clr_b_i,
  input  logic              write_d_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FN_W-1:0]   fn_nbr_i,
  input  logic [FN_W-1:0]   fn_mem_i,
  output logic [NBR_N-1:0]  nbr_o,
  output logic              rd_bit_o,
  output logic              a_o,
  output logic              b_o
);
  logic       a_q, b_q, hit, op_b, mem_bit;
  logic [1:0] fn_y;

  nbr_count #(.N(NBR_N), .THR_W(THR_W)) i_count (
    .rst_ni (rst_ni),
    .nbr_i  (nbr_i),
    .en_i   (nbr_en_i),
    .thr_i  (thresh_i),
    .hit_o  (hit)
  );

  assign op_b = b_q | hit;

  bool_unit #(.OUTS(2)) i_bool (
    .a_i  (a_q),
    .b_i  (op_b),
    .fn_i ({fn_mem_i, fn_nbr_i}),
    .y_o  (fn_y)
  );

  bit_mem #(.DEPTH(MEM_D), .ADDR_W(ADDR_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (write_d_i),
    .addr_i  (addr_i),
    .wdata_i (fn_y[1]),
    .rd_o    (mem_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      if (load_a_i) a_q <= mem_bit;
      if (clr_b_i)       b_q <= 1'b0;
      else if (load_b_i) b_q <= mem_bit;
    end
  end

  assign nbr_o    = {NBR_N{fn_y[0]}};
  assign rd_bit_o = mem_bit;
  assign a_o      = a_q;
  assign b_o      = b_q;

  // R8
  clr_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_b_i |=> !b_q);
  // R7
  load_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_a_i |=> a_q == $past(mem_bit));
  // R9
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_a_i |=> $stable(a_q));
  // R5
  always_comb begin
    if (rst_ni) nbr_uniform_chk: assert (nbr_o == '0 || nbr_o == '1);
  end
endmodule

// File: tb/test_nbr_thresh_pe.sv
module test_nbr_thresh_pe;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] nbr_i = '0, nbr_en_i = '0, nbr_o;
  logic [2:0] thresh_i = '0;
  logic       load_a_i = 0, load_b_i = 0, clr_b_i = 0, write_d_i = 0;
  logic [3:0] addr_i = '0, fn_nbr_i = '0, fn_mem_i = '0;
  logic       rd_bit_o, a_o, b_o;

  int checks = 0, fails = 0;
  bit ref_mem [16];
  bit ref_a = 0, ref_b = 0;

  always #2 clk_i = ~clk_i;

  nbr_thresh_pe i_nbr_thresh_pe (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive one control word after negedge, check outputs, advance model at posedge.
  task automatic step(string tag, logic [7:0] n, logic [7:0] e, logic [2:0] th,
                      logic la, logic lb, logic cb, logic wd, logic [3:0] ad,
                      logic [3:0] fn, logic [3:0] fm);
    int cnt;
    bit hit, bt, nb, mb, rdv;
    @(negedge clk_i);
    nbr_i = n; nbr_en_i = e; thresh_i = th; load_a_i = la; load_b_i = lb;
    clr_b_i = cb; write_d_i = wd; addr_i = ad; fn_nbr_i = fn; fn_mem_i = fm;
    cnt = 0;
    for (int i = 0; i < 8; i++) if (n[i] && e[i]) cnt++;
    hit = (cnt > int'(th));
    bt  = ref_b | hit;
    nb  = fn[{ref_a, bt}];
    mb  = fm[{ref_a, bt}];
    rdv = ref_mem[ad];
    #1;
    chk({tag, " R5 nbr_o"}, nbr_o, {8{nb}});
    chk({tag, " R6 rd_bit"}, {7'd0, rd_bit_o}, {7'd0, rdv});
    chk({tag, " R9 a"}, {7'd0, a_o}, {7'd0, ref_a});
    chk({tag, " R9 b"}, {7'd0, b_o}, {7'd0, ref_b});
    @(posedge clk_i);
    if (wd) ref_mem[ad] = mb;
    if (la) ref_a = rdv;
    if (cb) ref_b = 0; else if (lb) ref_b = rdv;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 0;
    #11 rst_ni = 1'b1;
    // R1: reset state at every address
    for (int i = 0; i < 16; i++) step("R1 reset", 0, 0, 0, 0, 0, 0, 0, 4'(i), 4'h0, 4'h0);
    // R6: write ones (fn_mem = all-ones) to addresses 1,3,5
    step("R6 wr1", 0, 0, 0, 0, 0, 0, 1, 4'd1, 4'h0, 4'hF);
    step("R6 wr3", 0, 0, 0, 0, 0, 0, 1, 4'd3, 4'h0, 4'hF);
    step("R6 wr5", 0, 0, 0, 0, 0, 0, 1, 4'd5, 4'h0, 4'hF);
    // R3: A=B=0, fn_nbr=0010 passes B|hit. count==thr gives 0, count>thr gives 1
    for (int t = 0; t < 8; t++) begin
      step("R3 eq", 8'((1 << t) - 1), 8'hFF, 3'(t), 0, 0, 0, 0, 4'd0, 4'b0010, 4'h0);
      step("R3 gt", 8'((1 << (t + 1)) - 1), 8'hFF, 3'(t), 0, 0, 0, 0, 4'd0, 4'b0010, 4'h0);
    end
    // R2: all high neighbours masked off -> no hit
    step("R2 mask", 8'hFF, 8'h00, 3'd0, 0, 0, 0, 0, 4'd0, 4'b0010, 4'h0);
    step("R2 part", 8'hFF, 8'h03, 3'd2, 0, 0, 0, 0, 4'd0, 4'b0010, 4'h0);
    step("R2 part2", 8'hF0, 8'h0F, 3'd0, 0, 0, 0, 0, 4'd0, 4'b0010, 4'h0);
    // R7: load A and B from addr 1 (=1)
    step("R7 load", 0, 0, 0, 1, 1, 0, 0, 4'd1, 4'h0, 4'h0);
    // R8: clear wins over load
    step("R8 clr", 0, 0, 0, 0, 1, 1, 0, 4'd1, 4'h0, 4'h0);
    // R4: A=1, B=0; fn 1000 = A AND (B|hit)
    step("R4 nohit", 8'h00, 8'hFF, 3'd0, 0, 0, 0, 0, 4'd0, 4'b1000, 4'h0);
    step("R4 hit", 8'h01, 8'hFF, 3'd0, 0, 0, 0, 0, 4'd0, 4'b1000, 4'h0);
    // R7: same-cycle load and write of addr 3 (holds 1); write 0 -> regs get old 1
    step("R7 same", 0, 0, 0, 1, 1, 0, 1, 4'd3, 4'h0, 4'h0);
    step("R7 after", 0, 0, 0, 0, 0, 0, 0, 4'd3, 4'h0, 4'h0);
    // R6: write result of A XOR (B|hit) with hit
    step("R6 xor", 8'h01, 8'h01, 3'd0, 0, 1, 1, 1, 4'd7, 4'h6, 4'h6);
    step("R6 xor2", 0, 0, 0, 0, 0, 0, 0, 4'd7, 4'h6, 4'h6);
    // mixed random control words
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      logic [31:0] s = $urandom;
      step("RND", r[7:0], r[15:8], r[18:16], r[19], r[20], r[21] & r[22],
           r[23], r[27:24], s[3:0], s[7:4]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule